// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block is the second rate-reduction stage of a digital down-converter. It sits after an integrate-and-comb decimator and takes that stage's output at 4 MHz. It lowpass filters the stream and keeps every second result, so a 2 MHz stream goes on to the final shaping filter, which does not decimate. The block accepts one signed 12-bit sample on each clock where the input strobe is high. For every two accepted samples it emits one rounded and saturated 12-bit result, and marks it with a one-clock valid pulse.

The impulse response has eleven taps and is symmetric. The taps at even distances from the centre, apart from the centre itself, are zero, so those taps are never read. The centre tap is one half and is built as a shift. Each pair of mirrored non-zero taps is added before its single multiply. A result costs three multiplies, and one is computed only on the input that completes a pair. This gives half the multiplies of a full filter that is run on every input and then thinned.

Top module: `hb_decim2`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `out_valid` is 0 and `out_data` is 0. Reset empties the sample history (as if all past samples were 0) and restarts the pairing, so the first result follows the second accepted sample after reset.
- R2: `out_valid` goes high for exactly one clock, on the clock edge after each even-numbered accepted sample (the 2nd, 4th, ... since reset). It is never high on two consecutive clocks.
- R3: Let x0 be the sample just accepted and xk the sample accepted k strobes earlier. The result is S = 16384*x5 + 9984*(x4+x6) - 2176*(x2+x8) + 384*(x0+x10), in units of 2^-15, then rounded and limited as R4 and R7 state. `out_data` is two's complement.
- R4: A rounded result above 2047 is output as 2047, and one below -2048 as -2048.
- R5: A clock with `in_valid` low does not change the history or the pairing. `out_valid` is 0 on the following clock, and `out_data` holds its last value.
- R6: Samples x1, x3, x7 and x9 have no effect on the result.
- R7: Rounding is half-up: the output is floor((S + 16384) / 32768). For example, a lone centre sample of 1 gives 1, of -1 gives 0, of 3 gives 2, and of -3 gives -1.
- R8: The pairing counts only accepted samples, so any number of idle clocks between the two samples of a pair does not move the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_data` is accepted on this clock |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | 12 | Signed filtered, decimated result |

## Verification
The hardest case to reach from the ports is saturation. The output overflows only when the three largest positive taps hold near full-scale values of one sign while the negative pair holds values of the other sign. Random samples almost never line up that way. The bench therefore loads complete eleven-sample windows with those values. It adds a leading pad sample when needed so that the window lands on an even input and produces a result. The same window loader isolates the four skipped positions and the centre sample to probe the zero taps and the rounding of halves. Long random runs with sparse strobes then cover the pairing across idle gaps, and a reset in the middle of a run checks that the history is emptied.

// File: rtl/hb_pkg.sv
package hb_pkg;

   // decimation phase: which half of an input pair comes next
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } hb_phase_e;

   // number of non-zero mirrored pairs for a half-band length
   function automatic int hb_pairs(input int ntaps);
      return (ntaps + 1) / 4;
   endfunction

   // a half-band length must be 4m+3 so the outermost taps are non-zero
   function automatic bit hb_len_ok(input int ntaps);
      return (ntaps >= 3) && (((ntaps - 3) % 4) == 0);
   endfunction

endpackage

// File: rtl/hb_tapline.sv
module hb_tapline #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shift_en,
   input  logic [DATA_W-1:0]             din,
   output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hb_tapline: DEPTH must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        taps[0] <= '0;
               else if (shift_en) taps[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        taps[i] <= '0;
               else if (shift_en) taps[i] <= taps[i-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hb_phase.sv
module hb_phase
   import hb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic fire
);

   hb_phase_e phase_q;

   // the second sample of each accepted pair triggers a result
   assign fire = accept && (phase_q == PH_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
      end else if (accept) begin
         phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
      end
   end

endmodule

// File: rtl/hb_mac.sv
module hb_mac
   import hb_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 15,
   parameter int NTAPS     = 11,
   parameter int ACC_W     = 32,
   parameter int NPAIR     = hb_pairs(NTAPS),
   parameter logic [NPAIR-1:0][COEF_W-1:0] COEFS = '0
) (
   input  logic [NTAPS-1:0][DATA_W-1:0] window,
   output logic signed [ACC_W-1:0]      acc
);

   localparam int CI     = (NTAPS - 1) / 2;
   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;

   generate
      if (ACC_W < PROD_W + 2) begin : g_bad_acc
         $error("hb_mac: ACC_W too narrow for the pair products");
      end
      if (COEF_FRAC < 1) begin : g_bad_frac
         $error("hb_mac: COEF_FRAC must be at least 1 to form the one-half centre tap");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod [NPAIR];

   genvar k;
   generate
      for (k = 0; k < NPAIR; k++) begin : g_pair
         localparam int OFF = 2 * k + 1;
         logic signed [PRE_W-1:0] pre;
         // fold mirrored samples so each non-zero coefficient is used once
         assign pre = PRE_W'(signed'(window[CI-OFF])) + PRE_W'(signed'(window[CI+OFF]));
         assign prod[k] = PROD_W'(pre) * PROD_W'(signed'(COEFS[k]));
      end
   endgenerate

   always_comb begin
      // centre coefficient of one half is a shift by COEF_FRAC-1
      acc = ACC_W'(signed'(window[CI])) <<< (COEF_FRAC - 1);
      for (int p = 0; p < NPAIR; p++) begin
         acc = acc + ACC_W'(prod[p]);
      end
   end

endmodule

// File: rtl/hb_rndsat.sv
module hb_rndsat #(
   parameter int ACC_W       = 32,
   parameter int FRAC        = 15,
   parameter int OUT_W       = 12,
   parameter bit RND_HALF_UP = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OUT_W-1:0] dout
);

   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

   generate
      if (FRAC < 1 || FRAC >= ACC_W - OUT_W) begin : g_bad_frac
         $error("hb_rndsat: FRAC out of range for ACC_W and OUT_W");
      end
   endgenerate

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] scaled;

   generate
      if (RND_HALF_UP) begin : g_round
         localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
         assign biased = acc + HALF;
      end else begin : g_trunc
         assign biased = acc;
      end
   endgenerate

   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > MAXV)      dout = MAXV[OUT_W-1:0];
      else if (scaled < MINV) dout = MINV[OUT_W-1:0];
      else                    dout = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
   import hb_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int COEF_W      = 16,
   parameter int COEF_FRAC   = 15,
   parameter int NTAPS       = 11,
   parameter bit RND_HALF_UP = 1'b1,
   parameter int NPAIR       = hb_pairs(NTAPS),
   parameter logic [NPAIR-1:0][COEF_W-1:0] COEFS =
      {16'sd384, -16'sd2176, 16'sd9984}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);

   localparam int DEPTH = NTAPS - 1;
   localparam int ACC_W = DATA_W + 1 + COEF_W + $clog2(NPAIR + 1) + 1;

   generate
      if (!hb_len_ok(NTAPS)) begin : g_bad_len
         $error("hb_decim2: NTAPS must be of the form 4m+3");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("hb_decim2: DATA_W must be at least 2");
      end
      if (COEF_FRAC >= COEF_W + DATA_W) begin : g_bad_cfrac
         $error("hb_decim2: COEF_FRAC too large");
      end
   endgenerate

   logic [DEPTH-1:0][DATA_W-1:0] taps;
   logic [NTAPS-1:0][DATA_W-1:0] window;
   logic                         fire;
   logic signed [ACC_W-1:0]      acc;
   logic signed [DATA_W-1:0]     res;

   hb_tapline #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_tapline (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .din      (in_data),
      .taps     (taps)
   );

   // newest sample sits in slot 0 so the result includes the current input
   assign window = {taps, in_data};

   hb_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (in_valid),
      .fire   (fire)
   );

   hb_mac #(
      .DATA_W    (DATA_W),
      .COEF_W    (COEF_W),
      .COEF_FRAC (COEF_FRAC),
      .NTAPS     (NTAPS),
      .ACC_W     (ACC_W),
      .NPAIR     (NPAIR),
      .COEFS     (COEFS)
   ) u_mac (
      .window (window),
      .acc    (acc)
   );

   hb_rndsat #(
      .ACC_W       (ACC_W),
      .FRAC        (COEF_FRAC),
      .OUT_W       (DATA_W),
      .RND_HALF_UP (RND_HALF_UP)
   ) u_rndsat (
      .acc  (acc),
      .dout (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) out_data <= res;
      end
   end

endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);

   // parity of accepted samples since reset, kept independently of the design
   logic par_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        par_q <= 1'b0;
      else if (in_valid) par_q <= ~par_q;
   end

   // R1: first clock after reset release carries no result
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!out_valid && out_data == '0));

   // R2: valid never lasts two clocks
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8: a result only follows an even count of accepted samples
   p_even_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (par_q == 1'b0));

   // R5: an idle clock never produces a result
   p_idle_no_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R5: output data only moves together with the valid pulse
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

endmodule

bind hb_decim2 hb_decim2_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_hb_decim2.sv
`timescale 1ns/1ps
module sim_hb_decim2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [11:0] in_data = '0;
   logic              out_valid;
   logic signed [11:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model state
   int hist [11];
   int acc_cnt = 0;
   int last_out = 0;

   always #2.5 clk = ~clk;

   hb_decim2 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   function automatic int model_out();
      int s;
      int r;
      s = 16384 * hist[5] + 9984 * (hist[4] + hist[6])
          - 2176 * (hist[2] + hist[8]) + 384 * (hist[0] + hist[10]);
      r = (s + 16384) >>> 15;
      if (r > 2047)  r = 2047;
      if (r < -2048) r = -2048;
      return r;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 11; i++) hist[i] = 0;
      acc_cnt  = 0;
      last_out = 0;
   endtask

   // drive one clock of input, then check the result of that edge
   task automatic step(bit v, int d, string tag);
      bit exp_v;
      in_valid = v;
      in_data  = 12'(d);
      @(posedge clk);
      #1;
      exp_v = 1'b0;
      if (v) begin
         for (int i = 10; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = d;
         acc_cnt++;
         if (acc_cnt % 2 == 0) begin
            exp_v = 1'b1;
            last_out = model_out();
         end
      end
      check(out_valid == exp_v, {tag, "/R2 valid"}, int'(out_valid), int'(exp_v));
      check(int'(out_data) == last_out, {tag, " data"}, int'(out_data), last_out);
   endtask

   // load a full window; w[k] is the sample k strobes before the newest
   task automatic load_window(int w [11], string tag);
      if (acc_cnt % 2 == 0) step(1'b1, 0, tag);
      for (int k = 10; k >= 0; k--) step(1'b1, w[k], tag);
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_data == 12'sd0, "R1 data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1 valid after release", int'(out_valid), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int w [11];
      void'($urandom(32'h5EED_0042));
      model_reset();
      do_reset();

      // R1: first sample gives nothing, second gives a result from an empty history
      step(1'b1, 700, "R1 first");
      step(1'b1, -300, "R1 second");

      // R5 / R8: idle clocks inside a pair carry junk that must be ignored
      step(1'b1, 1200, "R8 pair a");
      step(1'b0, 2047, "R5 idle");
      step(1'b0, -2048, "R5 idle");
      step(1'b0, 999, "R5 idle");
      step(1'b1, -900, "R8 pair b");
      step(1'b0, 1500, "R5 idle after");

      // R3: impulse walks through every tap position
      for (int k = 0; k < 12; k++) step(1'b1, (k == 0) ? 1024 : 0, "R3 impulse");

      // R4: positive and negative saturation
      w = '{2047, 0, -2048, 0, 2047, 2047, 2047, 0, -2048, 0, 2047};
      load_window(w, "R4 high");
      check(out_data == 12'sd2047, "R4 high clamp", int'(out_data), 2047);
      w = '{-2048, 0, 2047, 0, -2048, -2048, -2048, 0, 2047, 0, -2048};
      load_window(w, "R4 low");
      check(out_data == -12'sd2048, "R4 low clamp", int'(out_data), -2048);

      // R6: only the skipped positions carry signal
      w = '{0, 2047, 0, -2048, 0, 0, 0, 2047, 0, -1500, 0};
      load_window(w, "R6 zero taps");
      check(out_data == 12'sd0, "R6 skipped taps", int'(out_data), 0);

      // R7: rounding of exact halves on the centre tap
      w = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
      load_window(w, "R7 plus1");
      check(out_data == 12'sd1, "R7 half of 1", int'(out_data), 1);
      w = '{0, 0, 0, 0, 0, -1, 0, 0, 0, 0, 0};
      load_window(w, "R7 minus1");
      check(out_data == 12'sd0, "R7 half of -1", int'(out_data), 0);
      w = '{0, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0};
      load_window(w, "R7 plus3");
      check(out_data == 12'sd2, "R7 half of 3", int'(out_data), 2);
      w = '{0, 0, 0, 0, 0, -3, 0, 0, 0, 0, 0};
      load_window(w, "R7 minus3");
      check(out_data == -12'sd1, "R7 half of -3", int'(out_data), -1);

      // R3 / R8: random samples with random gaps
      for (int n = 0; n < 1500; n++) begin
         bit v;
         v = ($urandom % 3) != 0;
         step(v, int'($urandom % 4096) - 2048, "R3 random");
      end

      // R1: reset mid-stream clears history and pairing
      step(1'b1, 123, "R1 pre");
      do_reset();
      step(1'b1, 2000, "R1 restart first");
      step(1'b1, 2000, "R1 restart second");

      // R3: dense full-scale random to stress sums near the limits
      for (int n = 0; n < 600; n++) begin
         step(1'b1, ($urandom % 2) ? 2047 - int'($urandom % 64) : -2048 + int'($urandom % 64),
              "R4 dense");
      end

      in_valid = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule